// File: doc/BRIEF.md
# Delta LCD panel timing generator

This block produces every drive pulse needed by a small delta-arranged active-matrix LCD panel whose row and column shift-register drivers are built into the glass. It runs on a master pixel clock, and every duration is a parameter counted in master clock cycles. It takes single-cycle line and field sync references, a scan-direction select, an aspect-mode select and a line-drop pattern. It drives the horizontal start pulse, a complementary two-phase horizontal shift clock, the vertical start pulse and vertical shift clock, the gate enable, the uniformity clear pulse, the top/bottom blanking pulse and the line polarity flag.

Each accepted line reference starts a fixed sequence in the horizontal state machine. The states are `S_OFF` (after reset, left on the first field reference), `S_IDLE` (waits for a line reference), `S_CLR` (clear pulse high), `S_GAP` (clear low, start not yet raised) and `S_RUN` (horizontal clock running, start pulse high at its head). The transitions are: `S_OFF -> S_IDLE` on the field reference; `S_IDLE -> S_CLR` on a line reference; `S_CLR -> S_GAP` after `CLR_W` cycles; `S_GAP -> S_RUN` after `GAP` cycles; `S_RUN -> S_IDLE` after `2*HPULSES*HALF` cycles. The vertical clock changes level once per line, inside the clear pulse. A separate line sequencer tracks the line index within the field for the start, blanking and enable outputs.

Top module: `delta_panel_tg`

## Requirements
- R1: After reset, and until the first `vsync_ref`, `clr`, `hst`, `vst`, `vck`, `gate_en`, `blk` and `line_pol` are 0, `hck1` equals `!scan_rev` and `hck2` equals `scan_rev`. A `hsync_ref` in this period starts no line.
- R2: A `hsync_ref` accepted at clock edge E0 makes `clr` high from E0 for exactly `CLR_W` cycles.
- R3: `vck` changes level exactly once per accepted line, `VCK_LEAD` cycles before `clr` falls.
- R4: `hst` rises `GAP` cycles after `clr` falls, stays high for `2*HALF` cycles, and is never high together with `clr`.
- R5: From `HALF` cycles after `hst` rises, the horizontal clock changes level every `HALF` cycles, `2*HPULSES` times per line. It comes back to its idle level, and `hck2` is always the complement of `hck1`.
- R6: With `scan_rev`=1 the two horizontal phases are swapped: `hck1` takes the level `hck2` would have with `scan_rev`=0.
- R7: After a `vsync_ref`, the next accepted line has `vst`=1 from E0 until the following accepted line. That line is line 0 of the field.
- R8: `line_pol` inverts at every accepted line.
- R9: `blk` is 0 whenever `wide_mode`=0. With `wide_mode`=1 it is high during the `S_RUN` window of lines with index below `BLK_TOP` or at least `ACTIVE_LINES-BLK_BOT`. The line index saturates at `ACTIVE_LINES`.
- R10: After the first field reference, `gate_en` is 0 on a line whose index modulo `DROP_N` selects a 1 bit of `drop_pattern` (bit k for residue k), and 1 otherwise.
- R11: A `hsync_ref` arriving while a line sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master pixel clock |
| rst_n | input | 1 | active-low asynchronous reset |
| hsync_ref | input | 1 | single-cycle line reference |
| vsync_ref | input | 1 | single-cycle field reference |
| scan_rev | input | 1 | 1 selects right-to-left column scan |
| wide_mode | input | 1 | 1 selects widescreen mode with blanking |
| drop_pattern | input | DROP_N | lines to drop, indexed by line residue |
| hst | output | 1 | horizontal start pulse |
| hck1 | output | 1 | horizontal shift clock, phase 1 |
| hck2 | output | 1 | horizontal shift clock, phase 2 |
| vst | output | 1 | vertical start pulse |
| vck | output | 1 | vertical shift clock, one level change per line |
| gate_en | output | 1 | row gate enable |
| clr | output | 1 | uniformity clear pulse |
| blk | output | 1 | top/bottom blanking pulse |
| line_pol | output | 1 | video drive polarity of the current line |

## Verification
Take E0 as the edge that accepts a line reference. At the sample after edge E0+j, `clr` is due for j below `CLR_W`, and the new `vck` level from j=`CLR_W-VCK_LEAD`. `hst` and `blk` follow from j=`CLR_W+GAP`. Each horizontal clock change appears `HALF` samples after the one before it. `vst`, `gate_en` and `line_pol` take their new line values at j=0. The bench drives inputs and samples outputs on the falling edge. It records every output at each j from 0 to 29 of each line and compares it with a value computed from j and the parameters. It also injects a mid-line reference to show that nothing shifts.

// File: rtl/dptg_pkg.sv
package dptg_pkg;
    typedef enum logic [2:0] {
        S_OFF,
        S_IDLE,
        S_CLR,
        S_GAP,
        S_RUN
    } hstate_t;
endpackage

// File: rtl/dptg_hseq.sv
module dptg_hseq
    import dptg_pkg::*;
#(
    parameter int CLR_W    = 6,
    parameter int VCK_LEAD = 2,
    parameter int GAP      = 3,
    parameter int HALF     = 2,
    parameter int HPULSES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_ref,
    input  logic vsync_ref,
    input  logic scan_rev,
    output logic clr,
    output logic hst,
    output logic hck1,
    output logic hck2,
    output logic run,
    output logic active,
    output logic line_start,
    output logic vck_tick
);
    localparam int RUN_LEN = 2 * HPULSES * HALF;
    localparam int M1   = (CLR_W > GAP) ? CLR_W : GAP;
    localparam int MAXC = (M1 > RUN_LEN) ? M1 : RUN_LEN;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int HW   = $clog2(HALF + 1);
    localparam logic [CW-1:0] CLR_END  = CW'(CLR_W - 1);
    localparam logic [CW-1:0] GAP_END  = CW'(GAP - 1);
    localparam logic [CW-1:0] RUN_END  = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] VCK_AT   = CW'(CLR_W - 1 - VCK_LEAD);
    localparam logic [CW-1:0] HST_LEN  = CW'(2 * HALF);
    localparam logic [HW-1:0] HALF_END = HW'(HALF - 1);

    hstate_t        state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [HW-1:0]  hc_q;
    logic           hph_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:  if (vsync_ref)          state_d = S_IDLE;
            S_IDLE: if (hsync_ref)          state_d = S_CLR;
            S_CLR:  if (cnt_q == CLR_END)   state_d = S_GAP;
            S_GAP:  if (cnt_q == GAP_END)   state_d = S_RUN;
            S_RUN:  if (cnt_q == RUN_END)   state_d = S_IDLE;
            default:                        state_d = S_OFF;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
            hc_q    <= '0;
            hph_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == S_RUN) begin
                hc_q <= (hc_q == HALF_END) ? '0 : hc_q + 1'b1;
                if (hc_q == HALF_END) hph_q <= ~hph_q;
            end else begin
                hc_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        active     = (state_q != S_OFF);
        run        = (state_q == S_RUN);
        clr        = (state_q == S_CLR);
        hst        = (state_q == S_RUN) && (cnt_q < HST_LEN);
        line_start = (state_q == S_IDLE) && hsync_ref;
        vck_tick   = (state_q == S_CLR) && (cnt_q == VCK_AT);
        hck1       = hph_q ^ scan_rev;
        hck2       = ~(hph_q ^ scan_rev);
    end

    p_hck_compl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hck1 != hck2);
    p_clr_hst_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && hst));
    p_hst_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hst) |=> $stable(hph_q));
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && hsync_ref) |=> state_q != S_CLR);
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF) |-> (!clr && !hst && hph_q));
endmodule

// File: rtl/dptg_vseq.sv
module dptg_vseq #(
    parameter int ACTIVE_LINES = 8,
    parameter int BLK_TOP      = 1,
    parameter int BLK_BOT      = 1,
    parameter int DROP_N       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_ref,
    input  logic              wide_mode,
    input  logic [DROP_N-1:0] drop_pattern,
    input  logic              line_start,
    input  logic              vck_tick,
    input  logic              run,
    input  logic              active,
    output logic              vst,
    output logic              vck,
    output logic              gate_en,
    output logic              blk,
    output logic              line_pol
);
    localparam int LW = $clog2(ACTIVE_LINES + 1);
    localparam int PW = (DROP_N > 1) ? $clog2(DROP_N) : 1;
    localparam logic [LW-1:0] LN_MAX   = LW'(ACTIVE_LINES);
    localparam logic [LW-1:0] TOP_END  = LW'(BLK_TOP);
    localparam logic [LW-1:0] BOT_FROM = LW'(ACTIVE_LINES - BLK_BOT);
    localparam logic [PW-1:0] PH_MAX   = PW'(DROP_N - 1);

    logic          pend_q;
    logic [LW-1:0] ln_q;
    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            ln_q     <= '0;
            ph_q     <= '0;
            vst      <= 1'b0;
            vck      <= 1'b0;
            line_pol <= 1'b0;
        end else begin
            if (vck_tick) vck <= ~vck;
            if (line_start) begin
                line_pol <= ~line_pol;
                vst      <= pend_q;
                if (pend_q) begin
                    ln_q <= '0;
                    ph_q <= '0;
                end else begin
                    ln_q <= (ln_q == LN_MAX) ? LN_MAX : ln_q + 1'b1;
                    ph_q <= (ph_q == PH_MAX) ? '0 : ph_q + 1'b1;
                end
                pend_q <= vsync_ref;
            end else if (vsync_ref) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        gate_en = active && !drop_pattern[ph_q];
        blk     = wide_mode && run && ((ln_q < TOP_END) || (ln_q >= BOT_FROM));
    end

    p_blk_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> !blk);
    p_vck_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vck) |-> $past(vck_tick));
    p_pol_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> line_pol != $past(line_pol));
    p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !gate_en);
endmodule

// File: rtl/delta_panel_tg.sv
module delta_panel_tg #(
    parameter int CLR_W        = 6,
    parameter int VCK_LEAD     = 2,
    parameter int GAP          = 3,
    parameter int HALF         = 2,
    parameter int HPULSES      = 4,
    parameter int ACTIVE_LINES = 8,
    parameter int BLK_TOP      = 1,
    parameter int BLK_BOT      = 1,
    parameter int DROP_N       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_ref,
    input  logic              vsync_ref,
    input  logic              scan_rev,
    input  logic              wide_mode,
    input  logic [DROP_N-1:0] drop_pattern,
    output logic              hst,
    output logic              hck1,
    output logic              hck2,
    output logic              vst,
    output logic              vck,
    output logic              gate_en,
    output logic              clr,
    output logic              blk,
    output logic              line_pol
);
    logic run, active, line_start, vck_tick;

    dptg_hseq #(
        .CLR_W(CLR_W), .VCK_LEAD(VCK_LEAD), .GAP(GAP),
        .HALF(HALF), .HPULSES(HPULSES)
    ) u_hseq (
        .clk(clk), .rst_n(rst_n), .hsync_ref(hsync_ref),
        .vsync_ref(vsync_ref), .scan_rev(scan_rev),
        .clr(clr), .hst(hst), .hck1(hck1), .hck2(hck2),
        .run(run), .active(active), .line_start(line_start),
        .vck_tick(vck_tick)
    );

    dptg_vseq #(
        .ACTIVE_LINES(ACTIVE_LINES), .BLK_TOP(BLK_TOP),
        .BLK_BOT(BLK_BOT), .DROP_N(DROP_N)
    ) u_vseq (
        .clk(clk), .rst_n(rst_n), .vsync_ref(vsync_ref),
        .wide_mode(wide_mode), .drop_pattern(drop_pattern),
        .line_start(line_start), .vck_tick(vck_tick), .run(run),
        .active(active), .vst(vst), .vck(vck), .gate_en(gate_en),
        .blk(blk), .line_pol(line_pol)
    );
endmodule

// File: tb/tb_delta_panel_tg.sv
`timescale 1ns/1ps
module tb_delta_panel_tg;
    localparam int CLR_W = 6, VCK_LEAD = 2, GAP = 3, HALF = 2, HPULSES = 4;
    localparam int ACT = 8, BT = 1, BB = 1, DROP_N = 4;
    localparam int R0 = CLR_W + GAP;
    localparam int RUNL = 2 * HPULSES * HALF;
    localparam int SPAN = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hsync_ref = 0, vsync_ref = 0, scan_rev = 0, wide_mode = 0;
    logic [DROP_N-1:0] drop_pattern = '0;
    logic hst, hck1, hck2, vst, vck, gate_en, clr, blk, line_pol;

    int checks = 0, errors = 0, cyc = 0;
    logic vck_e = 1'b0, pol_e = 1'b0;

    always #2.5 clk = ~clk;

    delta_panel_tg dut (
        .clk(clk), .rst_n(rst_n), .hsync_ref(hsync_ref), .vsync_ref(vsync_ref),
        .scan_rev(scan_rev), .wide_mode(wide_mode), .drop_pattern(drop_pattern),
        .hst(hst), .hck1(hck1), .hck2(hck2), .vst(vst), .vck(vck),
        .gate_en(gate_en), .clr(clr), .blk(blk), .line_pol(line_pol)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp, input int ln, input int j);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s line %0d j %0d: got %b expected %b", tag, ln, j, got, exp);
        end
    endtask

    // one line: reference accepted at edge E0, samples j=0..SPAN-1 after E0+j
    task automatic do_line(input int ln, input int raw, input logic extra);
        int t;
        logic hexp, bexp;
        hsync_ref = 1'b1;
        @(negedge clk);
        hsync_ref = 1'b0;
        pol_e = ~pol_e;
        for (int j = 0; j < SPAN; j++) begin
            if (extra && j == 12) hsync_ref = 1'b1;       // R11 mid-line reference
            if (extra && j == 13) hsync_ref = 1'b0;
            chk("R2 clr", clr, j < CLR_W, ln, j);
            chk("R3 vck", vck, vck_e ^ (j >= CLR_W - VCK_LEAD), ln, j);
            chk("R4 hst", hst, (j >= R0) && (j < R0 + 2 * HALF), ln, j);
            t = (j < R0) ? 0 : ((j - R0) / HALF);
            if (t > 2 * HPULSES) t = 2 * HPULSES;
            hexp = (!scan_rev) ^ t[0];
            chk(scan_rev ? "R6 hck1" : "R5 hck1", hck1, hexp, ln, j);
            chk("R5 hck2", hck2, ~hexp, ln, j);
            chk("R7 vst", vst, ln == 0, ln, j);
            chk("R8 line_pol", line_pol, pol_e, ln, j);
            chk("R10 gate_en", gate_en, !drop_pattern[raw % DROP_N], ln, j);
            bexp = wide_mode && (ln < BT || ln >= ACT - BB) && j >= R0 && j < R0 + RUNL;
            chk("R9 blk", blk, bexp, ln, j);
            @(negedge clk);
        end
        vck_e = ~vck_e;
    endtask

    task automatic do_field(input logic rev, input logic wide, input logic [DROP_N-1:0] pat);
        int ln;
        scan_rev = rev; wide_mode = wide; drop_pattern = pat;
        vsync_ref = 1'b1;
        @(negedge clk);
        vsync_ref = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            ln = (k > ACT) ? ACT : k;
            do_line(ln, k, k == 4);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 clr", clr, 1'b0, -1, 0);
        chk("R1 hst", hst, 1'b0, -1, 0);
        chk("R1 vst", vst, 1'b0, -1, 0);
        chk("R1 vck", vck, 1'b0, -1, 0);
        chk("R1 gate_en", gate_en, 1'b0, -1, 0);
        chk("R1 blk", blk, 1'b0, -1, 0);
        chk("R1 line_pol", line_pol, 1'b0, -1, 0);
        chk("R1 hck1", hck1, 1'b1, -1, 0);
        chk("R1 hck2", hck2, 1'b0, -1, 0);
        // R1 line reference before any field reference starts nothing
        hsync_ref = 1'b1;
        @(negedge clk);
        hsync_ref = 1'b0;
        for (int j = 0; j < 12; j++) begin
            chk("R1 clr idle", clr, 1'b0, -1, j);
            chk("R1 vck idle", vck, 1'b0, -1, j);
            chk("R1 pol idle", line_pol, 1'b0, -1, j);
            @(negedge clk);
        end
        do_field(1'b0, 1'b0, 4'b0000);
        do_field(1'b1, 1'b1, 4'b0101);
        do_field(1'b0, 1'b1, 4'b1000);
        do_field(1'b1, 1'b0, 4'b0110);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule